// File: doc/BRIEF.md
# Serial Sampling Converter Host

This block is a master that runs in the system clock domain and controls a 12-bit successive-approximation converter. The converter has only a chip-select input, a serial-clock input and a serial-data output. The host drives an active-low chip select and a divided serial clock. It shifts in 16-bit frames and passes each 12-bit result to a valid/ready stream.

Three single-cycle command strobes drive the block: take a sample, power the converter down, and wake it up. The converter has no registers, so the host keeps its own record of the converter's power state.

- Power-down is a truncated 8-clock frame.
- Wake-up is a full-length frame whose data is thrown away.
- A sample requested while the converter sleeps is preceded automatically by a wake-up frame.
- After reset, one wake-up frame runs by itself, because the converter's power state at that point is unknown.

Successive frames are kept apart by a minimum chip-select-high time. That time is the larger of the quiet-time and pulse-width parameters, counted in system clocks. A sample request waits while an earlier sample is still held on the stream.

Top module: `adcm_host`

## Requirements
- R1: Outside reset, the frame timing is as follows:
  - The serial clock idles high.
  - After chip select falls, the serial clock stays high for HALF_DIV system clocks.
  - While chip select is low, every serial-clock level lasts exactly HALF_DIV system clocks.
  - Chip select and the serial clock rise together HALF_DIV clocks after the last falling edge.
  - Every frame has exactly 16 or exactly 8 falling edges.
- R2: The host samples the serial-data input just before each serial-clock falling edge, at falls 1 to 16. It drops the values taken at falls 1 to 4. The values taken at falls 5 to 16 become `smp_data[11]` down to `smp_data[0]`, MSB first, in the order the sample frames occurred.
- R3: A sleep command while the converter is awake produces one frame with exactly 8 falling edges. That frame delivers no sample.
- R4: A wake command while the converter is asleep produces one 16-edge frame whose data is discarded. A wake command while it is awake produces no frame.
- R5: A sleep command while the converter is already asleep produces no frame.
- R6: A sample command while the converter is asleep produces a 16-edge wake frame, then a 16-edge sample frame. Only the second frame delivers a sample.
- R7: After reset, the host runs exactly one 16-edge frame without any command, and no sample is delivered from it.
- R8: Chip select stays high for at least max(QUIET_CYC, CSH_CYC) system clocks before each fall.
- R9: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` is unchanged. No new sample frame starts while a sample is held.
- R10: A sample command that arrives during a frame is remembered and served after that frame and the gap.
- R11: During reset, `adc_cs_n` and `adc_sclk` are 1 and `smp_valid` is 0.
- R12: Whenever `adc_cs_n` is high, `adc_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sample | input | 1 | Strobe: take one sample |
| cmd_sleep | input | 1 | Strobe: power the converter down |
| cmd_wake | input | 1 | Strobe: wake the converter |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| smp_valid | output | 1 | Stream: sample available |
| smp_ready | input | 1 | Stream: sink accepts sample |
| smp_data | output | 12 | Stream: sample code, straight binary |

## Verification
The assertions check the following on every cycle:
- the serial clock is idle-high outside frames;
- the inter-frame gap is respected;
- the falling-edge count of each frame stays within its bound;
- a sample frame never starts while the converter is believed asleep or while the stream holds a sample;
- a held sample stays stable.

Only the bench's scenarios can show the following:
- the sequences that depend on history, namely the automatic wake before a sample, the ignored redundant sleep and wake commands, the initial dummy frame and the serving of a pending request;
- the correct bit order of the data.

For these, the bench runs a behavioural converter model that changes power state according to how many falling edges each frame carries.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
    localparam int FRAME_CLKS = 16;
    localparam int SLEEP_CLKS = 8;
    localparam int LEAD_ZEROS = 4;
    localparam int SAMPLE_W   = FRAME_CLKS - LEAD_ZEROS;
    localparam int FALL_W     = $clog2(FRAME_CLKS + 1);

    typedef enum logic [1:0] {FR_NONE, FR_WAKE, FR_SAMPLE, FR_SLEEP} frame_e;
    typedef enum logic [1:0] {EN_IDLE, EN_LEAD, EN_SHIFT} eng_st_e;

    typedef struct packed {
        frame_e                kind;
        logic [SAMPLE_W-1:0]   word;
    } frame_res_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [FALL_W-1:0] frame_len(frame_e k);
        return (k == FR_SLEEP) ? FALL_W'(SLEEP_CLKS) : FALL_W'(FRAME_CLKS);
    endfunction
endpackage

// File: rtl/adcm_seq.sv
module adcm_seq
    import adcm_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GAP_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  frame_e     kind,
    input  logic       sdata,
    output logic       cs_n,
    output logic       sclk,
    output logic       ready,
    output logic       done,
    output frame_res_t res
);
    localparam int PH_W  = $clog2(HALF_DIV + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    eng_st_e             st;
    logic [PH_W-1:0]     ph;
    logic [FALL_W-1:0]   nfall;
    logic [GAP_W-1:0]    gap_cnt;
    frame_e              cur;
    logic [SAMPLE_W-1:0] sh;
    logic                ph_end;

    assign ph_end   = (ph == PH_W'(HALF_DIV - 1));
    assign ready    = (st == EN_IDLE) && (gap_cnt == GAP_W'(GAP_CYC - 1));
    assign res.kind = cur;
    assign res.word = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= EN_IDLE;
            ph      <= '0;
            nfall   <= '0;
            gap_cnt <= GAP_W'(GAP_CYC - 1);
            cur     <= FR_NONE;
            sh      <= '0;
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                EN_IDLE: begin
                    if (gap_cnt != GAP_W'(GAP_CYC - 1))
                        gap_cnt <= gap_cnt + 1'b1;
                    if (start && ready) begin
                        st    <= EN_LEAD;
                        cs_n  <= 1'b0;
                        ph    <= '0;
                        cur   <= kind;
                        nfall <= '0;
                    end
                end
                EN_LEAD: begin
                    if (ph_end) begin
                        st    <= EN_SHIFT;
                        ph    <= '0;
                        sclk  <= 1'b0;
                        nfall <= FALL_W'(1);
                        sh    <= {sh[SAMPLE_W-2:0], sdata};
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                EN_SHIFT: begin
                    if (ph_end) begin
                        ph <= '0;
                        if (!sclk) begin
                            if (nfall == frame_len(cur)) begin
                                st      <= EN_IDLE;
                                cs_n    <= 1'b1;
                                sclk    <= 1'b1;
                                done    <= 1'b1;
                                gap_cnt <= '0;
                            end else begin
                                sclk <= 1'b1;
                            end
                        end else begin
                            sclk  <= 1'b0;
                            nfall <= nfall + 1'b1;
                            sh    <= {sh[SAMPLE_W-2:0], sdata};
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // independent count of chip-select-high cycles for the gap check
    logic [GAP_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= GAP_W'(GAP_CYC);
        else if (!cs_n)
            hi_run <= '0;
        else if (hi_run != GAP_W'(GAP_CYC))
            hi_run <= hi_run + 1'b1;
    end

    a_r8_gap_kept: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_run >= GAP_W'(GAP_CYC)));
    a_r12_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);
    a_r1_fall_bound: assert property (@(posedge clk) disable iff (rst)
        nfall <= FALL_W'(FRAME_CLKS));
    a_r3_sleep_short: assert property (@(posedge clk) disable iff (rst)
        (st == EN_SHIFT && cur == FR_SLEEP) |-> (nfall <= FALL_W'(SLEEP_CLKS)));
endmodule

// File: rtl/adcm_sched.sv
module adcm_sched
    import adcm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_sample,
    input  logic   cmd_sleep,
    input  logic   cmd_wake,
    input  logic   eng_ready,
    input  logic   out_busy,
    output logic   start,
    output frame_e kind
);
    logic   awake;
    logic   p_smp, p_slp, p_wak;
    frame_e pick;
    logic   idle_asleep;

    always_comb begin
        pick = FR_NONE;
        if (p_wak && !awake)
            pick = FR_WAKE;
        else if (p_smp)
            pick = !awake ? FR_WAKE : (out_busy ? FR_NONE : FR_SAMPLE);
        else if (p_slp && awake)
            pick = FR_SLEEP;
    end

    assign start       = eng_ready && (pick != FR_NONE);
    assign kind        = pick;
    assign idle_asleep = eng_ready && !awake && !p_smp && !p_wak;

    always_ff @(posedge clk) begin
        if (rst) begin
            awake <= 1'b0;
            p_wak <= 1'b1;
            p_smp <= 1'b0;
            p_slp <= 1'b0;
        end else begin
            if (start && pick == FR_WAKE)  awake <= 1'b1;
            if (start && pick == FR_SLEEP) awake <= 1'b0;
            p_wak <= cmd_wake   | (p_wak & ~awake & ~(start && pick == FR_WAKE));
            p_smp <= cmd_sample | (p_smp & ~(start && pick == FR_SAMPLE));
            p_slp <= cmd_sleep  | (p_slp & ~(start && pick == FR_SLEEP) & ~idle_asleep);
        end
    end

    a_r6_sample_when_awake: assert property (@(posedge clk) disable iff (rst)
        (start && kind == FR_SAMPLE) |-> awake);
    a_r9_no_sample_while_held: assert property (@(posedge clk) disable iff (rst)
        (start && kind == FR_SAMPLE) |-> !out_busy);
    a_r5_sleep_only_awake: assert property (@(posedge clk) disable iff (rst)
        (start && kind == FR_SLEEP) |-> awake);
    a_r4_wake_only_asleep: assert property (@(posedge clk) disable iff (rst)
        (start && kind == FR_WAKE) |-> !awake);
endmodule

// File: rtl/adcm_out.sv
module adcm_out
    import adcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  frame_res_t          res,
    input  logic                smp_ready,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else if (done && res.kind == FR_SAMPLE) begin
            smp_valid <= 1'b1;
            smp_data  <= res.word;
        end else if (smp_valid && smp_ready) begin
            smp_valid <= 1'b0;
        end
    end

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));
    a_r7_discard_dummy: assert property (@(posedge clk) disable iff (rst)
        (done && res.kind != FR_SAMPLE && !smp_valid) |=> !smp_valid);
endmodule

// File: rtl/adcm_host.sv
module adcm_host
    import adcm_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int QUIET_CYC = 4,
    parameter int CSH_CYC   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_sample,
    input  logic                cmd_sleep,
    input  logic                cmd_wake,
    input  logic                adc_sdata,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic                smp_valid,
    input  logic                smp_ready,
    output logic [SAMPLE_W-1:0] smp_data
);
    localparam int GAP_CYC = max2(QUIET_CYC, CSH_CYC);

    logic       eng_ready, eng_start, eng_done;
    frame_e     eng_kind;
    frame_res_t eng_res;

    adcm_sched i_sched (
        .clk        (clk),
        .rst        (rst),
        .cmd_sample (cmd_sample),
        .cmd_sleep  (cmd_sleep),
        .cmd_wake   (cmd_wake),
        .eng_ready  (eng_ready),
        .out_busy   (smp_valid),
        .start      (eng_start),
        .kind       (eng_kind)
    );

    adcm_seq #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) i_seq (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .kind  (eng_kind),
        .sdata (adc_sdata),
        .cs_n  (adc_cs_n),
        .sclk  (adc_sclk),
        .ready (eng_ready),
        .done  (eng_done),
        .res   (eng_res)
    );

    adcm_out i_out (
        .clk       (clk),
        .rst       (rst),
        .done      (eng_done),
        .res       (eng_res),
        .smp_ready (smp_ready),
        .smp_valid (smp_valid),
        .smp_data  (smp_data)
    );
endmodule

// File: tb/test_adcm_host.sv
module test_adcm_host;
    localparam int HALF  = 3;
    localparam int QUIET = 5;
    localparam int CSH   = 7;
    localparam int GAP   = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_sample = 1'b0, cmd_sleep = 1'b0, cmd_wake = 1'b0;
    logic        sdata_r = 1'b0;
    logic        cs_n, sclk, smp_valid;
    logic        smp_ready = 1'b1;
    logic [11:0] smp_data;

    adcm_host #(.HALF_DIV(HALF), .QUIET_CYC(QUIET), .CSH_CYC(CSH)) i_adcm_host (
        .clk(clk), .rst(rst), .cmd_sample(cmd_sample), .cmd_sleep(cmd_sleep),
        .cmd_wake(cmd_wake), .adc_sdata(sdata_r), .adc_cs_n(cs_n), .adc_sclk(sclk),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
    );

    initial forever #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural converter and reference model
    int  exp_q[$];
    bit  conv_awake = 0, awake_start = 0;
    int  frames = 0, accepted = 0, last_falls = 0, falls = 0;
    int  lvl = 0, hi_cnt = 1000, bit_idx = 0, frame_idx = 0;
    logic [11:0] fval = '0, pd = '0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1, pv = 1'b0, pr = 1'b0;

    function automatic logic [11:0] value_of(int idx);
        case (idx % 4)
            0:       return 12'hFFF;
            1:       return 12'h000;
            2:       return 12'h800;
            default: return 12'((idx * 1237 + 291) & 4095);
        endcase
    endfunction

    function automatic logic bit_at(int idx, bit awk, logic [11:0] v);
        if (!awk) return 1'b1;
        if (idx < 4 || idx > 15) return 1'b0;
        return v[15 - idx];
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            chk(!(cs_n && !sclk), "R12", int'(sclk), 1);
            if (prev_cs && !cs_n) begin
                chk(hi_cnt >= GAP, "R8", hi_cnt, GAP);
                falls = 0; lvl = 1; bit_idx = 0;
                awake_start = conv_awake;
                fval = value_of(frame_idx);
                frame_idx++;
                sdata_r = bit_at(0, awake_start, fval);
            end else if (!prev_cs && cs_n) begin
                chk(lvl == HALF, "R1", lvl, HALF);
                chk(falls == 16 || falls == 8, "R1", falls, 16);
                if (falls >= 10) begin
                    if (awake_start && falls == 16) exp_q.push_back(int'(fval));
                    conv_awake = 1;
                end else if (falls >= 2) begin
                    conv_awake = 0;
                end
                frames++; last_falls = falls; hi_cnt = 1;
            end else if (!cs_n) begin
                if (sclk != prev_sclk) begin
                    chk(lvl == HALF, "R1", lvl, HALF);
                    lvl = 1;
                    if (!sclk) begin
                        falls++; bit_idx++;
                        sdata_r = bit_at(bit_idx, awake_start, fval);
                    end
                end else begin
                    lvl++;
                end
            end else begin
                hi_cnt++;
            end
            if (pv && !pr)
                chk(smp_valid && smp_data == pd, "R9", int'(smp_data), int'(pd));
            if (smp_valid && smp_ready) begin
                accepted++;
                if (exp_q.size() == 0) chk(0, "R2", int'(smp_data), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(smp_data) == e, "R2", int'(smp_data), e);
                end
            end
            pv = smp_valid; pr = smp_ready; pd = smp_data;
        end
        prev_cs = cs_n; prev_sclk = sclk;
    end

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_sample();
        cmd_sample = 1'b1; wait_n(1); cmd_sample = 1'b0;
    endtask
    task automatic pulse_sleep();
        cmd_sleep = 1'b1; wait_n(1); cmd_sleep = 1'b0;
    endtask
    task automatic pulse_wake();
        cmd_wake = 1'b1; wait_n(1); cmd_wake = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        wait_n(3);
        chk(cs_n == 1'b1, "R11", int'(cs_n), 1);
        chk(sclk == 1'b1, "R11", int'(sclk), 1);
        chk(smp_valid == 1'b0, "R11", int'(smp_valid), 0);
        rst = 1'b0;
        wait_n(250);
        chk(frames == 1, "R7", frames, 1);
        chk(last_falls == 16, "R7", last_falls, 16);
        chk(accepted == 0 && !smp_valid, "R7", accepted, 0);
        chk(conv_awake, "R7", int'(conv_awake), 1);

        for (int i = 0; i < 3; i++) begin
            pulse_sample();
            wait_n(150);
        end
        chk(accepted == 3, "R2", accepted, 3);
        chk(frames == 4, "R1", frames, 4);

        pulse_sample(); wait_n(20); pulse_sample(); wait_n(300);
        chk(frames == 6, "R10", frames, 6);
        chk(accepted == 5, "R10", accepted, 5);

        pulse_sleep(); wait_n(150);
        chk(frames == 7, "R3", frames, 7);
        chk(last_falls == 8, "R3", last_falls, 8);
        chk(!conv_awake, "R3", int'(conv_awake), 0);
        chk(accepted == 5, "R3", accepted, 5);

        pulse_sleep(); wait_n(150);
        chk(frames == 7, "R5", frames, 7);

        pulse_sample(); wait_n(300);
        chk(frames == 9, "R6", frames, 9);
        chk(accepted == 6, "R6", accepted, 6);
        chk(conv_awake, "R6", int'(conv_awake), 1);

        pulse_wake(); wait_n(150);
        chk(frames == 9, "R4", frames, 9);
        pulse_sleep(); wait_n(150);
        pulse_wake(); wait_n(150);
        chk(frames == 11, "R4", frames, 11);
        chk(last_falls == 16, "R4", last_falls, 16);
        chk(accepted == 6, "R4", accepted, 6);
        chk(conv_awake, "R4", int'(conv_awake), 1);
        pulse_sample(); wait_n(150);
        chk(accepted == 7, "R4", accepted, 7);

        smp_ready = 1'b0;
        pulse_sample(); wait_n(150);
        pulse_sample(); wait_n(300);
        chk(frames == 13, "R9", frames, 13);
        chk(smp_valid == 1'b1, "R9", int'(smp_valid), 1);
        smp_ready = 1'b1;
        wait_n(200);
        chk(frames == 14, "R9", frames, 14);
        chk(accepted == 9, "R9", accepted, 9);
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
        summary();
    end
endmodule